// File: doc/BRIEF.md
# Paged MDIO to 32-bit Register Bridge

This block sits behind an MDIO management port and gives a host access to a 32-bit internal register space using only 16-bit clause-22 transactions. The serial framing is handled elsewhere. The bridge receives one decoded transaction per `txn_valid` pulse, carrying the direction, the PHY address, the register number and the write data.

The word address of a 32-bit register has 16 bits. A byte address becomes a word address once its two low bits are dropped.

- A write to one fixed PHY/register pair loads a page register. The page register holds the upper nine word-address bits.
- The remaining seven bits come from the access itself. The PHY address, within a block of eight, gives three of them. The register number, shifted right by one, gives the other four.
- Register-number bit 0 selects the half of the word. An even register carries the low 16 bits and an odd register carries the high 16 bits.

The host writes a word high half first, then low half. The bridge latches the high half and issues a single 32-bit back-end write when the low half arrives. The host reads a word low half first. That even-register read fetches the whole word from the back end and holds the upper half, so the following odd-register read returns data from the same fetch. Back-end reads are combinational: `bus_rdata` must be valid in the cycle `bus_rd` is high.

Top module: `mdio_wide_reg_bridge`

## Requirements
- R1: After reset the block holds the following state, so a read of the page register or of any odd data register returns 0x0000:
  - `bus_wr`, `bus_rd` and `rd_valid` are low.
  - The page register is 0.
  - Both half latches are 0.
- R2: A write to PHY 0x1F, register 0x10 stores `txn_wdata[8:0]` as word-address bits 15:7 and ignores the upper write bits. It causes no back-end access. A read of that same pair returns the page value zero-extended to 16 bits.
- R3: A data access uses a PHY address in the range 0x10 to 0x17. Its word address is the page register, then PHY bits 2:0, then register bits 4:1, from most to least significant. `bus_addr` carries that word address.
- R4: A data write to an odd register stores `txn_wdata` in the write-high latch. It issues no back-end write.
- R5: A data write to an even register raises `bus_wr` for one cycle, starting the cycle after the transaction. In that cycle `bus_wdata` is {write-high latch, `txn_wdata`}, and `bus_rd` is never high together with `bus_wr`.
- R6: A data read of an even register raises `bus_rd` for one cycle, starting the cycle after the transaction. The block captures all 32 bits of `bus_rdata` at the end of that cycle. `rd_valid` then pulses with `rd_data` equal to bits 15:0.
- R7: A data read of an odd register issues no back-end access. `rd_valid` pulses two cycles after the transaction with the high half captured by the most recent even read. This holds even when the odd read directly follows the even read.
- R8: The write-high latch keeps its value after a commit. A second even-register write with no odd write in between reuses the previous high half.
- R9: A transaction that is neither a page access nor a data access is void:
  - A void write changes no state and issues no back-end access.
  - A void read issues no back-end access and returns 0xFFFF two cycles later.
- R10: Every read transaction produces exactly one `rd_valid` pulse, two cycles after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txn_valid | input | 1 | One decoded MDIO transaction is present this cycle |
| txn_write | input | 1 | 1 = write transaction, 0 = read transaction |
| txn_phy | input | 5 | PHY address of the transaction |
| txn_reg | input | 5 | Register number of the transaction |
| txn_wdata | input | 16 | Write data of the transaction |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the read result |
| rd_data | output | 16 | Read result returned to the MDIO side |
| bus_wr | output | 1 | Back-end 32-bit write strobe |
| bus_rd | output | 1 | Back-end 32-bit read strobe |
| bus_addr | output | 16 | Back-end word address |
| bus_wdata | output | 32 | Back-end write data |
| bus_rdata | input | 32 | Back-end read data, valid while `bus_rd` is high |

## Verification
Results are due at the following times after a transaction, where "edge" means the clock edge that samples it:
- Back-end strobes, address and write data appear in the cycle after that edge.
- `rd_valid` and `rd_data` appear one cycle later still.

The bench drives every transaction just after a falling edge. It samples the back-end outputs at the next falling edge and the read response at the falling edge after that. Each such sample window is also the point at which the bench confirms the absence of a strobe that a given transaction must not produce.

For the coherency case the bench presents the odd read in the cycle directly after the even read. It then checks the two responses on consecutive falling edges.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  // Classification of one decoded management transaction.
  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_PAGE_WR = 3'd1,
    ACC_PAGE_RD = 3'd2,
    ACC_LO_WR   = 3'd3,
    ACC_HI_WR   = 3'd4,
    ACC_LO_RD   = 3'd5,
    ACC_HI_RD   = 3'd6,
    ACC_VOID_RD = 3'd7
  } acc_kind_e;

endpackage

// File: rtl/mdio_bridge_hold.sv
module mdio_bridge_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/mdio_bridge_decode.sv
module mdio_bridge_decode
  import mdio_bridge_pkg::*;
#(
  parameter logic [4:0] PAGE_PHY      = 5'h1F,
  parameter logic [4:0] PAGE_REG      = 5'h10,
  parameter logic [4:0] DATA_PHY_BASE = 5'h10,
  parameter int         SEL_W         = 3
) (
  input  logic             txn_valid,
  input  logic             txn_write,
  input  logic [4:0]       txn_phy,
  input  logic [4:0]       txn_reg,
  output acc_kind_e        kind,
  output logic [SEL_W-1:0] sel,
  output logic [3:0]       pair
);

  logic is_page;
  logic is_data;

  always_comb begin
    is_page = (txn_phy == PAGE_PHY) && (txn_reg == PAGE_REG);
    is_data = (txn_phy[4:SEL_W] == DATA_PHY_BASE[4:SEL_W]);
    sel     = txn_phy[SEL_W-1:0];
    pair    = txn_reg[4:1];
    kind    = ACC_NONE;
    if (txn_valid) begin
      if (is_page) begin
        kind = txn_write ? ACC_PAGE_WR : ACC_PAGE_RD;
      end else if (is_data) begin
        case ({txn_write, txn_reg[0]})
          2'b10:   kind = ACC_LO_WR;
          2'b11:   kind = ACC_HI_WR;
          2'b00:   kind = ACC_LO_RD;
          default: kind = ACC_HI_RD;
        endcase
      end else if (!txn_write) begin
        kind = ACC_VOID_RD;
      end
    end
  end

endmodule

// File: rtl/mdio_bridge_engine.sv
module mdio_bridge_engine
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int ADDR_W = 16,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  acc_kind_e           kind,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [HALF_W-1:0]   txn_wdata,
  input  logic [HALF_W-1:0]   wr_hi,
  input  logic [HALF_W-1:0]   rd_hi,
  input  logic [PAGE_W-1:0]   page,
  input  logic [2*HALF_W-1:0] bus_rdata,
  output logic                bus_wr,
  output logic                bus_rd,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [2*HALF_W-1:0] bus_wdata,
  output logic                rd_valid,
  output logic [HALF_W-1:0]   rd_data,
  output logic                rd_hi_en,
  output logic [HALF_W-1:0]   rd_hi_d
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int PAD_W  = HALF_W - PAGE_W;

  // Issue stage: back-end strobes and the pending local response.
  logic              bus_wr_nxt, bus_rd_nxt;
  logic [ADDR_W-1:0] bus_addr_nxt;
  logic [WORD_W-1:0] bus_wdata_nxt;
  logic              pend_q, pend_nxt;
  acc_kind_e         pend_kind_q, pend_kind_nxt;

  // Response stage.
  logic              rd_valid_nxt;
  logic [HALF_W-1:0] rd_data_nxt;

  always_comb begin
    bus_wr_nxt    = (kind == ACC_LO_WR);
    bus_rd_nxt    = (kind == ACC_LO_RD);
    bus_addr_nxt  = bus_addr;
    bus_wdata_nxt = bus_wdata;
    if (bus_wr_nxt || bus_rd_nxt) bus_addr_nxt = acc_addr;
    if (bus_wr_nxt) bus_wdata_nxt = {wr_hi, txn_wdata};
    pend_nxt      = (kind == ACC_PAGE_RD) || (kind == ACC_HI_RD) || (kind == ACC_VOID_RD);
    pend_kind_nxt = pend_kind_q;
    if (pend_nxt) pend_kind_nxt = kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_wr      <= 1'b0;
      bus_rd      <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      pend_q      <= 1'b0;
      pend_kind_q <= ACC_NONE;
    end else begin
      bus_wr      <= bus_wr_nxt;
      bus_rd      <= bus_rd_nxt;
      bus_addr    <= bus_addr_nxt;
      bus_wdata   <= bus_wdata_nxt;
      pend_q      <= pend_nxt;
      pend_kind_q <= pend_kind_nxt;
    end
  end

  // The local response is chosen one cycle late, so an odd read right
  // behind an even read sees the freshly captured high half.
  always_comb begin
    rd_hi_en     = bus_rd;
    rd_hi_d      = bus_rdata[WORD_W-1:HALF_W];
    rd_valid_nxt = bus_rd || pend_q;
    rd_data_nxt  = rd_data;
    if (bus_rd) begin
      rd_data_nxt = bus_rdata[HALF_W-1:0];
    end else if (pend_q) begin
      case (pend_kind_q)
        ACC_HI_RD:   rd_data_nxt = rd_hi;
        ACC_PAGE_RD: rd_data_nxt = {{PAD_W{1'b0}}, page};
        default:     rd_data_nxt = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_valid_nxt;
      rd_data  <= rd_data_nxt;
    end
  end

endmodule

// File: rtl/mdio_wide_reg_bridge.sv
module mdio_wide_reg_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int         PAGE_W        = 9,
  parameter int         SEL_W         = 3,
  parameter int         HALF_W        = 16,
  parameter logic [4:0] PAGE_PHY      = 5'h1F,
  parameter logic [4:0] PAGE_REG      = 5'h10,
  parameter logic [4:0] DATA_PHY_BASE = 5'h10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      txn_valid,
  input  logic                      txn_write,
  input  logic [4:0]                txn_phy,
  input  logic [4:0]                txn_reg,
  input  logic [HALF_W-1:0]         txn_wdata,
  output logic                      rd_valid,
  output logic [HALF_W-1:0]         rd_data,
  output logic                      bus_wr,
  output logic                      bus_rd,
  output logic [PAGE_W+SEL_W+3:0]   bus_addr,
  output logic [2*HALF_W-1:0]       bus_wdata,
  input  logic [2*HALF_W-1:0]       bus_rdata
);

  localparam int PAIR_W = 4;
  localparam int ADDR_W = PAGE_W + SEL_W + PAIR_W;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  acc_kind_e         kind;
  logic [SEL_W-1:0]  sel;
  logic [PAIR_W-1:0] pair;
  logic [PAGE_W-1:0] page_q;
  logic [HALF_W-1:0] wr_hi_q;
  logic [HALF_W-1:0] rd_hi_q;
  logic              rd_hi_en;
  logic [HALF_W-1:0] rd_hi_d;
  logic [ADDR_W-1:0] acc_addr;

  mdio_bridge_decode #(
    .PAGE_PHY      (PAGE_PHY),
    .PAGE_REG      (PAGE_REG),
    .DATA_PHY_BASE (DATA_PHY_BASE),
    .SEL_W         (SEL_W)
  ) i_decode (
    .txn_valid (txn_valid),
    .txn_write (txn_write),
    .txn_phy   (txn_phy),
    .txn_reg   (txn_reg),
    .kind      (kind),
    .sel       (sel),
    .pair      (pair)
  );

  assign acc_addr = {page_q, sel, pair};

  mdio_bridge_hold #(.W(PAGE_W)) i_page (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (kind == ACC_PAGE_WR),
    .d     (txn_wdata[PAGE_W-1:0]),
    .q     (page_q)
  );

  mdio_bridge_hold #(.W(HALF_W)) i_wr_hi (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (kind == ACC_HI_WR),
    .d     (txn_wdata),
    .q     (wr_hi_q)
  );

  mdio_bridge_hold #(.W(HALF_W)) i_rd_hi (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (rd_hi_en),
    .d     (rd_hi_d),
    .q     (rd_hi_q)
  );

  mdio_bridge_engine #(
    .PAGE_W (PAGE_W),
    .ADDR_W (ADDR_W),
    .HALF_W (HALF_W)
  ) i_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .kind      (kind),
    .acc_addr  (acc_addr),
    .txn_wdata (txn_wdata),
    .wr_hi     (wr_hi_q),
    .rd_hi     (rd_hi_q),
    .page      (page_q),
    .bus_rdata (bus_rdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_hi_en  (rd_hi_en),
    .rd_hi_d   (rd_hi_d)
  );

endmodule

// File: rtl/mdio_bridge_props.sv
module mdio_bridge_props #(
  parameter int         PAGE_W        = 9,
  parameter int         SEL_W         = 3,
  parameter int         HALF_W        = 16,
  parameter logic [4:0] PAGE_PHY      = 5'h1F,
  parameter logic [4:0] PAGE_REG      = 5'h10,
  parameter logic [4:0] DATA_PHY_BASE = 5'h10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    txn_valid,
  input logic                    txn_write,
  input logic [4:0]              txn_phy,
  input logic [4:0]              txn_reg,
  input logic [HALF_W-1:0]       txn_wdata,
  input logic                    rd_valid,
  input logic [HALF_W-1:0]       rd_data,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [PAGE_W+SEL_W+3:0] bus_addr,
  input logic [2*HALF_W-1:0]     bus_wdata,
  input logic [2*HALF_W-1:0]     bus_rdata
);

  logic t_page, t_data, t_void;
  assign t_page = txn_valid && (txn_phy == PAGE_PHY) && (txn_reg == PAGE_REG);
  assign t_data = txn_valid && (txn_phy[4:SEL_W] == DATA_PHY_BASE[4:SEL_W]) && !t_page;
  assign t_void = txn_valid && !t_page && !t_data;

  p_page_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_page && txn_write) |=> (!bus_wr && !bus_rd));

  p_addr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (t_data && txn_write && !txn_reg[0]) |=>
      (bus_addr[SEL_W+3:0] == {$past(txn_phy[SEL_W-1:0]), $past(txn_reg[4:1])}));

  p_hi_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (t_data && txn_write && txn_reg[0]) |=> !bus_wr);

  p_lo_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_data && txn_write && !txn_reg[0]) |=>
      (bus_wr && (bus_wdata[HALF_W-1:0] == $past(txn_wdata))));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  p_lo_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (t_data && !txn_write && !txn_reg[0]) |=> bus_rd);

  p_lo_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (rd_valid && (rd_data == $past(bus_rdata[HALF_W-1:0]))));

  p_hi_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (t_data && !txn_write && txn_reg[0]) |=> !bus_rd);

  p_void_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_void |=> (!bus_wr && !bus_rd));

  p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_write) |=> ##1 rd_valid);

endmodule

bind mdio_wide_reg_bridge mdio_bridge_props #(
  .PAGE_W        (PAGE_W),
  .SEL_W         (SEL_W),
  .HALF_W        (HALF_W),
  .PAGE_PHY      (PAGE_PHY),
  .PAGE_REG      (PAGE_REG),
  .DATA_PHY_BASE (DATA_PHY_BASE)
) i_props (.*);

// File: tb/test_mdio_wide_reg_bridge.sv
`timescale 1ns/1ps
module test_mdio_wide_reg_bridge;

  logic        clk;
  logic        rst_n;
  logic        txn_valid;
  logic        txn_write;
  logic [4:0]  txn_phy;
  logic [4:0]  txn_reg;
  logic [15:0] txn_wdata;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Back-end model: each word address returns a fixed pattern.
  function automatic logic [31:0] model_word(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a + 16'h0101};
  endfunction
  assign bus_rdata = model_word(bus_addr);

  mdio_wide_reg_bridge i_mdio_wide_reg_bridge (
    .clk (clk), .rst_n (rst_n), .txn_valid (txn_valid), .txn_write (txn_write),
    .txn_phy (txn_phy), .txn_reg (txn_reg), .txn_wdata (txn_wdata),
    .rd_valid (rd_valid), .rd_data (rd_data), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Split a byte address into the PHY/register pair of its even half.
  function automatic logic [4:0] phy_of(input logic [17:0] byte_a);
    logic [15:0] w = byte_a[17:2];
    return 5'h10 | {2'b00, w[6:4]};
  endfunction
  function automatic logic [4:0] reg_of(input logic [17:0] byte_a);
    logic [15:0] w = byte_a[17:2];
    return {w[3:0], 1'b0};
  endfunction

  task automatic drive(input logic wr, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] d);
    txn_valid = 1'b1; txn_write = wr; txn_phy = phy; txn_reg = rg; txn_wdata = d;
  endtask

  task automatic idle();
    txn_valid = 1'b0; txn_write = 1'b0;
  endtask

  // Write transaction; reports strobes seen one cycle after it.
  task automatic mdio_wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d,
                         output logic wr_s, output logic rd_s,
                         output logic [15:0] a_s, output logic [31:0] d_s);
    @(negedge clk); drive(1'b1, phy, rg, d);
    @(negedge clk); idle();
    wr_s = bus_wr; rd_s = bus_rd; a_s = bus_addr; d_s = bus_wdata;
    @(negedge clk);
  endtask

  // Read transaction; reports strobe, response valid and data.
  task automatic mdio_rd(input logic [4:0] phy, input logic [4:0] rg,
                         output logic rd_s, output logic wr_s, output logic [15:0] a_s,
                         output logic v, output logic [15:0] d);
    @(negedge clk); drive(1'b0, phy, rg, 16'h0);
    @(negedge clk); idle();
    rd_s = bus_rd; wr_s = bus_wr; a_s = bus_addr;
    @(negedge clk);
    v = rd_valid; d = rd_data;
    @(negedge clk);
  endtask

  logic        s_wr, s_rd, s_v;
  logic [15:0] s_a, s_d;
  logic [31:0] s_wd;

  task automatic t_reset();
    check("R1", "bus_wr after reset", 32'(bus_wr), 32'd0);
    check("R1", "bus_rd after reset", 32'(bus_rd), 32'd0);
    check("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);
    mdio_rd(5'h1F, 5'h10, s_rd, s_wr, s_a, s_v, s_d);
    check("R1", "page after reset", 32'(s_d), 32'h0);
    mdio_rd(5'h13, 5'h07, s_rd, s_wr, s_a, s_v, s_d);
    check("R1", "read-high latch after reset", 32'(s_d), 32'h0);
    check("R1", "odd read valid", 32'(s_v), 32'd1);
  endtask

  task automatic t_page(input logic [15:0] raw, input logic [8:0] exp_page);
    mdio_wr(5'h1F, 5'h10, raw, s_wr, s_rd, s_a, s_wd);
    check("R2", "page write bus_wr", 32'(s_wr), 32'd0);
    check("R2", "page write bus_rd", 32'(s_rd), 32'd0);
    mdio_rd(5'h1F, 5'h10, s_rd, s_wr, s_a, s_v, s_d);
    check("R2", "page readback", 32'(s_d), 32'(exp_page));
    check("R10", "page read valid", 32'(s_v), 32'd1);
    check("R2", "page read no fetch", 32'(s_rd), 32'd0);
  endtask

  task automatic t_write_word(input logic [17:0] byte_a, input logic [31:0] word);
    logic [4:0] p = phy_of(byte_a);
    logic [4:0] r = reg_of(byte_a);
    mdio_wr(p, r | 5'h1, word[31:16], s_wr, s_rd, s_a, s_wd);
    check("R4", "odd write bus_wr", 32'(s_wr), 32'd0);
    mdio_wr(p, r, word[15:0], s_wr, s_rd, s_a, s_wd);
    check("R5", "even write bus_wr", 32'(s_wr), 32'd1);
    check("R5", "even write bus_rd", 32'(s_rd), 32'd0);
    check("R5", "committed word", s_wd, word);
    check("R3", "write word address", 32'(s_a), 32'(byte_a[17:2]));
    @(negedge clk);
    check("R5", "bus_wr single pulse", 32'(bus_wr), 32'd0);
  endtask

  task automatic t_read_word(input logic [17:0] byte_a);
    logic [4:0]  p = phy_of(byte_a);
    logic [4:0]  r = reg_of(byte_a);
    logic [31:0] w = model_word(byte_a[17:2]);
    mdio_rd(p, r, s_rd, s_wr, s_a, s_v, s_d);
    check("R6", "even read bus_rd", 32'(s_rd), 32'd1);
    check("R3", "read word address", 32'(s_a), 32'(byte_a[17:2]));
    check("R6", "low half", 32'(s_d), 32'(w[15:0]));
    check("R6", "low half valid", 32'(s_v), 32'd1);
    mdio_rd(p, r | 5'h1, s_rd, s_wr, s_a, s_v, s_d);
    check("R7", "odd read no fetch", 32'(s_rd), 32'd0);
    check("R7", "high half", 32'(s_d), 32'(w[31:16]));
  endtask

  task automatic t_back_to_back(input logic [17:0] byte_a);
    logic [4:0]  p = phy_of(byte_a);
    logic [4:0]  r = reg_of(byte_a);
    logic [31:0] w = model_word(byte_a[17:2]);
    @(negedge clk); drive(1'b0, p, r, 16'h0);
    @(negedge clk); drive(1'b0, p, r | 5'h1, 16'h0);
    check("R6", "b2b fetch strobe", 32'(bus_rd), 32'd1);
    @(negedge clk); idle();
    check("R6", "b2b low valid", 32'(rd_valid), 32'd1);
    check("R6", "b2b low half", 32'(rd_data), 32'(w[15:0]));
    check("R7", "b2b odd no fetch", 32'(bus_rd), 32'd0);
    @(negedge clk);
    check("R7", "b2b high valid", 32'(rd_valid), 32'd1);
    check("R7", "b2b high half", 32'(rd_data), 32'(w[31:16]));
    @(negedge clk);
    check("R10", "single response pulse", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_hi_persist(input logic [17:0] byte_a, input logic [15:0] hi,
                              input logic [15:0] lo);
    mdio_wr(phy_of(byte_a), reg_of(byte_a), lo, s_wr, s_rd, s_a, s_wd);
    check("R8", "reused high half", s_wd, {hi, lo});
    check("R8", "commit strobe", 32'(s_wr), 32'd1);
  endtask

  task automatic t_void(input logic [8:0] page_now, input logic [15:0] hi_now);
    mdio_wr(5'h05, 5'h02, 16'h0077, s_wr, s_rd, s_a, s_wd);
    check("R9", "void write phy 0x05 no access", 32'(s_wr | s_rd), 32'd0);
    mdio_wr(5'h1F, 5'h11, 16'h0033, s_wr, s_rd, s_a, s_wd);
    check("R9", "void write 0x1F/0x11 no access", 32'(s_wr | s_rd), 32'd0);
    mdio_wr(5'h18, 5'h01, 16'h4444, s_wr, s_rd, s_a, s_wd);
    check("R9", "void odd-reg write no access", 32'(s_wr | s_rd), 32'd0);
    mdio_rd(5'h1F, 5'h10, s_rd, s_wr, s_a, s_v, s_d);
    check("R9", "page untouched", 32'(s_d), 32'(page_now));
    mdio_rd(5'h08, 5'h00, s_rd, s_wr, s_a, s_v, s_d);
    check("R9", "void read data", 32'(s_d), 32'hFFFF);
    check("R9", "void read no fetch", 32'(s_rd), 32'd0);
    check("R10", "void read valid", 32'(s_v), 32'd1);
    mdio_wr(5'h10, 5'h00, 16'h0001, s_wr, s_rd, s_a, s_wd);
    check("R9", "write-high latch untouched", 32'(s_wd[31:16]), 32'(hi_now));
  endtask

  initial begin
    rst_n = 1'b0;
    idle(); txn_phy = '0; txn_reg = '0; txn_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_page(16'hF1A5, 9'h1A5);
    t_write_word({9'h1A5, 7'h5B, 2'b00}, 32'hBEEF_1234);
    t_read_word({9'h1A5, 7'h5B, 2'b00});
    t_back_to_back({9'h1A5, 7'h2E, 2'b00});
    t_hi_persist({9'h1A5, 7'h01, 2'b00}, 16'hBEEF, 16'h9876);
    t_page(16'h0E02, 9'h002);
    t_write_word({9'h002, 7'h7F, 2'b00}, 32'h0BAD_F00D);
    t_read_word({9'h002, 7'h00, 2'b00});
    t_void(9'h002, 16'h0BAD);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule